// File: doc/BRIEF.md
# Collective Vote, Match and Rank Unit

This block takes one W-bit value from each of N participants, all presented together once the participants have synchronised. Every participant then receives its own set of scheduling results, each computed over all N values: a tally of the participants whose value names it by index, a bitmap of those participants, a tally and bitmap of the participants holding exactly its own value, and the slot its value would take in an ascending sort. No data moves. Each participant learns only where it stands relative to the others.

The unit is sequenced. An accepted start strobe captures the whole value vector. In each of the next N cycles, one peer value is broadcast to N per-participant accumulators, which compare it against their own value in parallel. After the last peer has been visited, a one-cycle done strobe marks the results as valid. The results then hold until the next accepted start.

The controller has three states. IDLE waits for a start; the transition IDLE to SCAN (accept) loads the values and clears every accumulator. SCAN visits peers 0 to N-1, one per cycle; the transition SCAN to FINISH (last peer) happens on the visit to peer N-1. FINISH drives done for one cycle and then always returns to IDLE (release). A start seen in SCAN or FINISH has no effect.

Top module: `vmr_unit`

## Requirements
- R1: After reset, done_o is 0 and every result field is 0.
- R2: When start_i is accepted at a clock edge, done_o is 1 for exactly one cycle, and it rises after the N-th following clock edge.
- R3: When done_o is 1, the vote count of participant i (field `vote_cnt_o[i*CW +: CW]`, CW = clog2(N+1)) equals the number of participants whose value equals i. A value of N or greater names no participant and adds to no tally.
- R4: When done_o is 1, bit k of participant i's vote mask (`vote_mask_o[i*N + k]`) is 1 exactly when participant k's value equals i.
- R5: When done_o is 1, participant i's match count (`match_cnt_o[i*CW +: CW]`) equals the number of participants whose value equals participant i's value, counting i itself.
- R6: When done_o is 1, bit k of participant i's match mask (`match_mask_o[i*N + k]`) is 1 exactly when participant k's value equals participant i's value.
- R7: When done_o is 1, participant i's rank (`rank_o[i*IW +: IW]`, IW = clog2(N)) is the number of participants whose unsigned value is smaller than its own, plus the number with an equal value and a lower index. The ranks form a permutation of 0..N-1.
- R8: Participant values are `vals_i[i*W +: W]` and are sampled only when a start is accepted in IDLE. A start or a change of vals_i while a scan is in progress does not alter the results, and the results stay unchanged while the unit waits in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only in IDLE |
| vals_i | input | N*W | One value per participant, participant i at [i*W +: W] |
| done_o | output | 1 | One-cycle strobe: results valid |
| vote_cnt_o | output | N*CW | Per-participant vote tally |
| vote_mask_o | output | N*N | Per-participant voter bitmap |
| match_cnt_o | output | N*CW | Per-participant equal-value tally |
| match_mask_o | output | N*N | Per-participant equal-value bitmap |
| rank_o | output | N*IW | Per-participant ascending sort position |

## Verification
The bench drives a value set made entirely of equal values. A design that breaks ties wrongly gives duplicate ranks there, and a design that leaves a participant out of its own match gives a match count of N-1. It also uses values of N and well above N. A design that truncates the value to the index width before comparing would count those as votes for a low-numbered participant. The all-ones value and zero appear together, so a signed compare would misplace the ranks. Finally, the bench injects a second start with different values in the middle of a scan and then idles. A design that restarts, or that re-samples the inputs, would return the second set's results or would raise done at the wrong cycle.

// File: rtl/vmr_pkg.sv
`timescale 1ns/1ps
package vmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } vmr_state_e;
endpackage

// File: rtl/vmr_lane.sv
`timescale 1ns/1ps
// Per-participant accumulator: compares one broadcast peer per step.
module vmr_lane #(
    parameter int N    = 4,
    parameter int W    = 8,
    parameter int SELF = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  step_i,
    input  logic [IW-1:0]         idx_i,
    input  logic [W-1:0]          own_i,
    input  logic [W-1:0]          peer_i,
    output logic [CW-1:0]         vote_cnt_o,
    output logic [N-1:0]          vote_mask_o,
    output logic [CW-1:0]         match_cnt_o,
    output logic [N-1:0]          match_mask_o,
    output logic [IW-1:0]         rank_o
);
    localparam int CW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [W-1:0]  SELF_V = W'(SELF);
    localparam logic [IW-1:0] SELF_I = IW'(SELF);

    logic hit_vote, hit_match, below;

    always_comb begin
        hit_vote  = (peer_i == SELF_V);
        hit_match = (peer_i == own_i);
        below     = (peer_i < own_i) || (hit_match && (idx_i < SELF_I));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vote_cnt_o   <= '0;
            vote_mask_o  <= '0;
            match_cnt_o  <= '0;
            match_mask_o <= '0;
            rank_o       <= '0;
        end else if (clr_i) begin
            vote_cnt_o   <= '0;
            vote_mask_o  <= '0;
            match_cnt_o  <= '0;
            match_mask_o <= '0;
            rank_o       <= '0;
        end else if (step_i) begin
            if (hit_vote) begin
                vote_cnt_o         <= vote_cnt_o + CW'(1);
                vote_mask_o[idx_i] <= 1'b1;
            end
            if (hit_match) begin
                match_cnt_o         <= match_cnt_o + CW'(1);
                match_mask_o[idx_i] <= 1'b1;
            end
            if (below) rank_o <= rank_o + IW'(1);
        end
    end
endmodule

// File: rtl/vmr_seq.sv
`timescale 1ns/1ps
// Sequencer: IDLE -> SCAN (N peers) -> FINISH -> IDLE.
module vmr_seq #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                accept_o,
    output logic                step_o,
    output logic [IW-1:0]       idx_o,
    output logic                done_o,
    output vmr_pkg::vmr_state_e state_o
);
    import vmr_pkg::*;
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    vmr_state_e state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (start_i) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (idx_q == LAST) begin
                    state_d = ST_FINISH;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + IW'(1);
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o = 1'b0;
        step_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept_o = start_i;
            ST_SCAN:   step_o   = 1'b1;
            ST_FINISH: done_o   = 1'b1;
            default:   ;
        endcase
    end

    assign idx_o   = idx_q;
    assign state_o = state_q;
endmodule

// File: rtl/vmr_unit.sv
`timescale 1ns/1ps
module vmr_unit #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [N*W-1:0]       vals_i,
    output logic                 done_o,
    output logic [N*CW-1:0]      vote_cnt_o,
    output logic [N*N-1:0]       vote_mask_o,
    output logic [N*CW-1:0]      match_cnt_o,
    output logic [N*N-1:0]       match_mask_o,
    output logic [N*IW-1:0]      rank_o
);
    localparam int CW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic                accept, step;
    logic [IW-1:0]       idx;
    logic [W-1:0]        vals_q [N];
    logic [W-1:0]        peer;
    vmr_pkg::vmr_state_e state_w;

    vmr_seq #(.N(N)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .step_o   (step),
        .idx_o    (idx),
        .done_o   (done_o),
        .state_o  (state_w)
    );

    assign peer = vals_q[idx];

    for (genvar g = 0; g < N; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      vals_q[g] <= '0;
            else if (accept) vals_q[g] <= vals_i[g*W +: W];
        end

        vmr_lane #(.N(N), .W(W), .SELF(g)) lane_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr_i        (accept),
            .step_i       (step),
            .idx_i        (idx),
            .own_i        (vals_q[g]),
            .peer_i       (peer),
            .vote_cnt_o   (vote_cnt_o[g*CW +: CW]),
            .vote_mask_o  (vote_mask_o[g*N +: N]),
            .match_cnt_o  (match_cnt_o[g*CW +: CW]),
            .match_mask_o (match_mask_o[g*N +: N]),
            .rank_o       (rank_o[g*IW +: IW])
        );
    end
endmodule

// File: rtl/vmr_unit_chk.sv
`timescale 1ns/1ps
module vmr_unit_chk #(
    parameter int N = 4,
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                done_o,
    input vmr_pkg::vmr_state_e state,
    input logic [N*CW-1:0]     vote_cnt_o,
    input logic [N*N-1:0]      vote_mask_o,
    input logic [N*CW-1:0]     match_cnt_o,
    input logic [N*N-1:0]      match_mask_o,
    input logic [N*IW-1:0]     rank_o
);
    import vmr_pkg::*;
    localparam int CW = $clog2(N + 1);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int SW = $clog2(N + 2) + 1;

    logic [SW-1:0] since_q;
    logic [N-1:0]  perm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 since_q <= '0;
        else if (state == ST_IDLE && start_i)       since_q <= '0;
        else if (since_q != {SW{1'b1}})             since_q <= since_q + SW'(1);
    end

    always_comb begin
        perm = '0;
        for (int i = 0; i < N; i++) perm[rank_o[i*IW +: IW]] = 1'b1;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_q == SW'(N)));
    // R8
    scan_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |=> (state != ST_IDLE));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_i) |=> ($stable(rank_o) && $stable(match_mask_o) && $stable(vote_mask_o)));
    // R7
    rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (perm == {N{1'b1}}));

    for (genvar g = 0; g < N; g++) begin : g_port
        // R5
        self_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> match_mask_o[g*N + g]);
        // R6
        match_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> ($countones(match_mask_o[g*N +: N]) == int'(match_cnt_o[g*CW +: CW])));
        // R4
        vote_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> ($countones(vote_mask_o[g*N +: N]) == int'(vote_cnt_o[g*CW +: CW])));
    end
endmodule

bind vmr_unit vmr_unit_chk #(.N(N), .W(W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .done_o       (done_o),
    .state        (state_w),
    .vote_cnt_o   (vote_cnt_o),
    .vote_mask_o  (vote_mask_o),
    .match_cnt_o  (match_cnt_o),
    .match_mask_o (match_mask_o),
    .rank_o       (rank_o)
);

// File: tb/vmr_unit_tb.sv
`timescale 1ns/1ps
module vmr_unit_tb_top;
    localparam int N  = 4;
    localparam int W  = 8;
    localparam int CW = $clog2(N + 1);
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [N*W-1:0]  vals_i = '0;
    logic            done_o;
    logic [N*CW-1:0] vote_cnt_o, match_cnt_o;
    logic [N*N-1:0]  vote_mask_o, match_mask_o;
    logic [N*IW-1:0] rank_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vmr_unit #(.N(N), .W(W)) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .vals_i (vals_i),
        .done_o (done_o), .vote_cnt_o (vote_cnt_o), .vote_mask_o (vote_mask_o),
        .match_cnt_o (match_cnt_o), .match_mask_o (match_mask_o), .rank_o (rank_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model computed from the requirements and compared at the ports.
    task automatic check_results(input logic [N*W-1:0] v, input string tag);
        for (int i = 0; i < N; i++) begin
            int vc = 0, mc = 0, rk = 0;
            logic [N-1:0] vm = '0, mm = '0;
            for (int k = 0; k < N; k++) begin
                logic [W-1:0] vk = v[k*W +: W];
                logic [W-1:0] vi = v[i*W +: W];
                if (int'(vk) == i) begin vc++; vm[k] = 1'b1; end
                if (vk == vi) begin mc++; mm[k] = 1'b1; end
                if (vk < vi || (vk == vi && k < i)) rk++;
            end
            chk(int'(vote_cnt_o[i*CW +: CW]) == vc, "R3", {tag, " vote count"},
                vote_cnt_o[i*CW +: CW], vc);
            chk(vote_mask_o[i*N +: N] == vm, "R4", {tag, " vote mask"},
                vote_mask_o[i*N +: N], vm);
            chk(int'(match_cnt_o[i*CW +: CW]) == mc, "R5", {tag, " match count"},
                match_cnt_o[i*CW +: CW], mc);
            chk(match_mask_o[i*N +: N] == mm, "R6", {tag, " match mask"},
                match_mask_o[i*N +: N], mm);
            chk(int'(rank_o[i*IW +: IW]) == rk, "R7", {tag, " rank"},
                rank_o[i*IW +: IW], rk);
        end
    endtask

    task automatic run_case(input logic [N*W-1:0] v, input bit inject,
                            input logic [N*W-1:0] v2, input string tag);
        bit early = 1'b0;
        @(negedge clk);
        vals_i  = v;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (done_o) early = 1'b1;
        for (int j = 1; j < N; j++) begin
            if (inject && j == 1) begin
                vals_i  = v2;
                start_i = 1'b1;
            end
            @(posedge clk); #1;
            start_i = 1'b0;
            if (done_o) early = 1'b1;
        end
        chk(!early, "R2", {tag, " done before N edges"}, early, 0);
        @(posedge clk); #1;
        chk(done_o == 1'b1, "R2", {tag, " done after N edges"}, done_o, 1);
        check_results(v, tag);
        @(posedge clk); #1;
        chk(done_o == 1'b0, "R2", {tag, " done one cycle"}, done_o, 0);
        repeat (3) @(posedge clk);
        #1;
        check_results(v, {tag, " R8 hold"});
    endtask

    task automatic test_reset();
        chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
        chk(vote_cnt_o == '0 && match_cnt_o == '0, "R1", "reset counts",
            vote_cnt_o | match_cnt_o, 0);
        chk(vote_mask_o == '0 && match_mask_o == '0 && rank_o == '0, "R1",
            "reset masks and ranks", vote_mask_o | match_mask_o | rank_o, 0);
    endtask

    task automatic test_distinct();
        run_case({8'd1, 8'd2, 8'd0, 8'd3}, 1'b0, '0, "distinct");
    endtask

    task automatic test_all_equal();
        run_case({8'd2, 8'd2, 8'd2, 8'd2}, 1'b0, '0, "all-equal");
    endtask

    task automatic test_out_of_range();
        // R3: values 4, 7 and 200 name no participant.
        run_case({8'd4, 8'd1, 8'd200, 8'd7}, 1'b0, '0, "R3 out-of-range");
    endtask

    task automatic test_ties();
        run_case({8'd1, 8'd5, 8'd1, 8'd5}, 1'b0, '0, "R7 ties");
    endtask

    task automatic test_extremes();
        run_case({8'd128, 8'd255, 8'd0, 8'd255}, 1'b0, '0, "R7 extremes");
    endtask

    task automatic test_busy_start();
        run_case({8'd9, 8'd3, 8'd0, 8'd0}, 1'b1, {8'd0, 8'd3, 8'd2, 8'd1}, "R8 busy start");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_distinct();
        test_all_equal();
        test_out_of_range();
        test_ties();
        test_extremes();
        test_busy_start();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule